// File: doc/BRIEF.md
# Six-Step Accumulator Machine Sequencer

This block is a tiny bus-based accumulator machine with its control sequencer. A program counter, an address register, an instruction register, an accumulator, a temporary operand register, an adder and a sixteen-word program RAM all share one internal bus. A six-bit one-hot step ring selects, for each clock, which single source drives the bus and which registers capture it. Every instruction uses all six steps. Steps 1 to 3 fetch the instruction word and are the same for every opcode. Steps 4 to 6 carry out the opcode, and any step an opcode does not need does nothing.

Before releasing reset, the host fills the RAM through a write port. After reset the machine runs on its own. It loads the accumulator from memory, adds memory words into it, and stops when it meets the stop opcode. The accumulator, program counter, step ring, bus and a halted flag are visible at the ports.

Top module: `acc_seq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, accumulator and the other registers clear to zero, `tstate` becomes 6'b000001 (step 1) and `halted` is low.
- R2: `tstate` is one-hot, with bit 0 for step 1 through bit 5 for step 6. It moves one step per clock and returns from step 6 to step 1, so step 1 recurs every six clocks.
- R3: At most one source drives the bus in any step. In step 1 the bus carries the program counter, zero-extended, which the address register captures. In a step where nothing drives the bus, `bus_out` reads zero, and step 2 is such a step.
- R4: In step 2 the program counter increments by one and wraps from 15 to 0.
- R5: An instruction word holds the opcode in bits 7:4 and a RAM address in bits 3:0. Step 3 loads the RAM word at the address register into the instruction register. Step 4 copies bits 3:0 of the instruction into the address register for the load opcode 4'b0000 and the add opcode 4'b0001.
- R6: For the load opcode, step 5 writes the addressed RAM word into the accumulator, and step 6 changes nothing.
- R7: For the add opcode, step 5 writes the addressed RAM word into the temporary register, and step 6 writes accumulator plus temporary (modulo 256) into the accumulator exactly once.
- R8: The stop opcode 4'b1111 holds the ring at step 4 (`tstate` = 6'b001000) with `halted` high. No register changes until reset.
- R9: Any other opcode leaves the accumulator and address register unchanged in steps 4 to 6, and the machine goes on to the next instruction.
- R10: When `prog_we` is high at a clock edge, `prog_data` is written to the RAM word at `prog_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | RAM write strobe for program loading |
| prog_addr | input | 4 | RAM write address |
| prog_data | input | 8 | RAM write data |
| acc_out | output | 8 | Accumulator value |
| pc_out | output | 4 | Program counter value |
| tstate | output | 6 | One-hot timing step |
| halted | output | 1 | High while the stop opcode holds the ring |
| bus_out | output | 8 | Value on the shared internal bus |

## Verification
A corrupted step ring or opcode decode shows up within one instruction, which is six clocks. The next step-1 bus value no longer equals the program counter, or the spacing between step-1 visits breaks. A wrong address register, temporary register or adder result appears in the accumulator at the next step 1, where a reference interpreter in the bench has predicted both the accumulator and the program counter. A stop that fails to hold is visible at once in `tstate` and `halted`. Programs include an 8-bit overflow, an unknown opcode, program-counter wrap and a halt.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
    parameter int DW    = 8;
    parameter int AW    = 4;
    parameter int NSTEP = 6;
    localparam int OPW  = DW - AW;

    localparam logic [OPW-1:0] OP_LDA = OPW'(0);
    localparam logic [OPW-1:0] OP_ADD = OPW'(1);
    localparam logic [OPW-1:0] OP_HLT = {OPW{1'b1}};

    // step indices into the one-hot ring
    localparam int ST_ADDR = 0;
    localparam int ST_INCR = 1;
    localparam int ST_MEM  = 2;
    localparam int ST_EX1  = 3;
    localparam int ST_EX2  = 4;
    localparam int ST_EX3  = 5;

    typedef struct packed {
        logic pc_oe;
        logic ram_oe;
        logic ir_oe;
        logic sum_oe;
        logic mar_ld;
        logic ir_ld;
        logic a_ld;
        logic tmp_ld;
        logic pc_inc;
    } ctl_t;

    function automatic logic [OPW-1:0] op_field(input logic [DW-1:0] w);
        return w[DW-1:AW];
    endfunction

    function automatic logic [AW-1:0] addr_field(input logic [DW-1:0] w);
        return w[AW-1:0];
    endfunction
endpackage

// File: rtl/acc_step_ring.sv
module acc_step_ring #(
    parameter int NSTEP = acc_seq_pkg::NSTEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    output logic [NSTEP-1:0] step
);
    always_ff @(posedge clk) begin
        if (rst)
            step <= NSTEP'(1);
        else if (!hold)
            step <= {step[NSTEP-2:0], step[NSTEP-1]};
    end

    // R2: exactly one step active
    a_r2_ring_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot(step));

    // R8: stop holds the ring
    a_r8_halt_freeze: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(step));
endmodule

// File: rtl/acc_ctl_decode.sv
module acc_ctl_decode
    import acc_seq_pkg::*;
#(
    parameter int NSTEP = acc_seq_pkg::NSTEP,
    parameter int OPW_P = acc_seq_pkg::OPW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTEP-1:0] step,
    input  logic [OPW_P-1:0] opcode,
    output ctl_t             ctl,
    output logic             hold
);
    logic is_lda, is_add, is_hlt;

    always_comb begin
        is_lda = (opcode == OP_LDA);
        is_add = (opcode == OP_ADD);
        is_hlt = (opcode == OP_HLT);
        ctl    = '0;
        hold   = 1'b0;
        if (step[ST_ADDR]) begin
            ctl.pc_oe  = 1'b1;
            ctl.mar_ld = 1'b1;
        end
        if (step[ST_INCR])
            ctl.pc_inc = 1'b1;
        if (step[ST_MEM]) begin
            ctl.ram_oe = 1'b1;
            ctl.ir_ld  = 1'b1;
        end
        if (step[ST_EX1]) begin
            if (is_hlt)
                hold = 1'b1;
            else if (is_lda || is_add) begin
                ctl.ir_oe  = 1'b1;
                ctl.mar_ld = 1'b1;
            end
        end
        if (step[ST_EX2]) begin
            if (is_lda) begin
                ctl.ram_oe = 1'b1;
                ctl.a_ld   = 1'b1;
            end else if (is_add) begin
                ctl.ram_oe = 1'b1;
                ctl.tmp_ld = 1'b1;
            end
        end
        if (step[ST_EX3] && is_add) begin
            ctl.sum_oe = 1'b1;
            ctl.a_ld   = 1'b1;
        end
    end

    // R3: one bus driver at most
    a_r3_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.pc_oe, ctl.ram_oe, ctl.ir_oe, ctl.sum_oe}));

    // R8: no register load while stopped
    a_r8_no_load_halted: assert property (@(posedge clk) disable iff (rst)
        hold |-> !(ctl.a_ld || ctl.mar_ld || ctl.ir_ld || ctl.tmp_ld || ctl.pc_inc));
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_seq_pkg::*;
#(
    parameter int DW_P = acc_seq_pkg::DW,
    parameter int AW_P = acc_seq_pkg::AW
) (
    input  logic            clk,
    input  logic            rst,
    input  ctl_t            ctl,
    input  logic            prog_we,
    input  logic [AW_P-1:0] prog_addr,
    input  logic [DW_P-1:0] prog_data,
    output logic [DW_P-1:0] acc,
    output logic [AW_P-1:0] pc,
    output logic [DW_P-1:0] ir,
    output logic [DW_P-1:0] bus
);
    localparam int DEPTH = 1 << AW_P;

    logic [DW_P-1:0] mem [DEPTH];
    logic [AW_P-1:0] mar;
    logic [DW_P-1:0] tmp;
    logic [DW_P-1:0] ram_rd;
    logic [DW_P-1:0] sum;

    assign ram_rd = mem[mar];
    assign sum    = acc + tmp;

    // wired-OR bus; decoder guarantees a single enable
    assign bus = ({DW_P{ctl.pc_oe}}  & DW_P'(pc))
               | ({DW_P{ctl.ram_oe}} & ram_rd)
               | ({DW_P{ctl.ir_oe}}  & DW_P'(ir[AW_P-1:0]))
               | ({DW_P{ctl.sum_oe}} & sum);

    always_ff @(posedge clk) begin
        if (prog_we)
            mem[prog_addr] <= prog_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            ir  <= '0;
            acc <= '0;
            tmp <= '0;
        end else begin
            if (ctl.pc_inc) pc  <= pc + 1'b1;
            if (ctl.mar_ld) mar <= bus[AW_P-1:0];
            if (ctl.ir_ld)  ir  <= bus;
            if (ctl.a_ld)   acc <= bus;
            if (ctl.tmp_ld) tmp <= bus;
        end
    end

    // R4: increment step
    a_r4_pc_step: assert property (@(posedge clk) disable iff (rst)
        ctl.pc_inc |=> pc == AW_P'($past(pc) + 1'b1));

    // R5: fetch captures the addressed word
    a_r5_ir_fetch: assert property (@(posedge clk) disable iff (rst)
        ctl.ir_ld |=> ir == $past(ram_rd));

    // R6: load writes memory word into accumulator
    a_r6_load_acc: assert property (@(posedge clk) disable iff (rst)
        (ctl.a_ld && ctl.ram_oe) |=> acc == $past(ram_rd));

    // R7: single add per instruction
    a_r7_add_once: assert property (@(posedge clk) disable iff (rst)
        ctl.sum_oe |=> acc == DW_P'($past(acc) + $past(tmp)));
endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
    import acc_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data,
    output logic [DW-1:0] acc_out,
    output logic [AW-1:0] pc_out,
    output logic [NSTEP-1:0] tstate,
    output logic          halted,
    output logic [DW-1:0] bus_out
);
    ctl_t          ctl;
    logic          hold;
    logic [DW-1:0] ir;

    acc_step_ring #(.NSTEP(NSTEP)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .step (tstate)
    );

    acc_ctl_decode #(.NSTEP(NSTEP), .OPW_P(OPW)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .step   (tstate),
        .opcode (op_field(ir)),
        .ctl    (ctl),
        .hold   (hold)
    );

    acc_datapath #(.DW_P(DW), .AW_P(AW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .acc       (acc_out),
        .pc        (pc_out),
        .ir        (ir),
        .bus       (bus_out)
    );

    assign halted = hold;

    // R1: clean state right after reset
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tstate == NSTEP'(1) && pc_out == '0 && acc_out == '0));
endmodule

// File: tb/tb_acc_seq_top.sv
module tb_acc_seq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_we = 1'b0;
    logic [3:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic [7:0] acc_out;
    logic [3:0] pc_out;
    logic [5:0] tstate;
    logic       halted;
    logic [7:0] bus_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] model_mem [16];
    logic [3:0] q_pc  [$];
    logic [7:0] q_acc [$];
    string      q_tag [$];

    acc_seq_top dut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .acc_out(acc_out), .pc_out(pc_out),
        .tstate(tstate), .halted(halted), .bus_out(bus_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference interpreter: pushes expected (pc, acc) seen at each step 1
    task automatic run_model(input int n_instr, output bit stopped);
        logic [3:0] pc = '0;
        logic [7:0] a  = '0;
        stopped = 1'b0;
        for (int i = 0; i < n_instr; i++) begin
            logic [7:0] w;
            string tag;
            w  = model_mem[pc];
            pc = pc + 4'd1;
            case (w[7:4])
                4'b0000: begin a = model_mem[w[3:0]]; tag = "R6"; end
                4'b0001: begin a = a + model_mem[w[3:0]]; tag = "R7"; end
                4'b1111: begin stopped = 1'b1; end
                default: tag = "R9";
            endcase
            if (stopped) break;
            q_pc.push_back(pc);
            q_acc.push_back(a);
            q_tag.push_back(tag);
        end
    endtask

    task automatic load_and_reset();
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); #1;
            prog_we = 1'b1; prog_addr = 4'(i); prog_data = model_mem[i];
        end
        @(negedge clk); #1;
        prog_we = 1'b0;
        @(negedge clk);
        // R1
        chk(tstate == 6'b000001, "R1", "tstate", tstate, 1);
        chk(pc_out == 4'd0, "R1", "pc", pc_out, 0);
        chk(acc_out == 8'd0, "R1", "acc", acc_out, 0);
        chk(halted == 1'b0, "R1", "halted", halted, 0);
        #1 rst = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (q_pc.size() != 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(q_pc.size() == 0, "R2", "pending instructions", q_pc.size(), 0);
    endtask

    // monitor
    int since_t1 = 0;
    bit seen_t1  = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            since_t1 = 0;
            seen_t1  = 1'b0;
        end else begin
            since_t1++;
            if (tstate == 6'b000010)
                chk(bus_out == 8'd0, "R3", "idle bus in step 2", bus_out, 0);
            if (tstate == 6'b000001) begin
                chk(bus_out == {4'd0, pc_out}, "R3", "bus in step 1", bus_out, {4'd0, pc_out});
                if (seen_t1)
                    chk(since_t1 == 6, "R2", "clocks between step 1", since_t1, 6);
                seen_t1  = 1'b1;
                since_t1 = 0;
                if (q_pc.size() != 0) begin
                    logic [3:0] ep;
                    logic [7:0] ea;
                    string      et;
                    ep = q_pc.pop_front();
                    ea = q_acc.pop_front();
                    et = q_tag.pop_front();
                    chk(pc_out == ep, "R4", "pc after instruction", pc_out, ep);
                    chk(acc_out == ea, et, "acc after instruction (R5 R10)", acc_out, ea);
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit stopped;
        // program 1: load, two adds with 8-bit overflow, stop
        for (int i = 0; i < 16; i++) model_mem[i] = 8'h00;
        model_mem[0]  = 8'h09;
        model_mem[1]  = 8'h1A;
        model_mem[2]  = 8'h1B;
        model_mem[3]  = 8'hF0;
        model_mem[9]  = 8'h05;
        model_mem[10] = 8'h07;
        model_mem[11] = 8'hFE;
        run_model(16, stopped);
        load_and_reset();
        drain();
        repeat (8) @(negedge clk);
        // R8
        chk(halted == 1'b1, "R8", "halted", halted, 1);
        chk(tstate == 6'b001000, "R8", "tstate held", tstate, 8);
        chk(pc_out == 4'd4, "R8", "pc held", pc_out, 4);
        chk(acc_out == 8'h0A, "R7", "acc after overflow", acc_out, 8'h0A);
        repeat (12) @(negedge clk);
        chk(tstate == 6'b001000, "R8", "tstate still held", tstate, 8);
        chk(pc_out == 4'd4, "R8", "pc still held", pc_out, 4);
        chk(acc_out == 8'h0A, "R8", "acc still held", acc_out, 8'h0A);

        // program 2: unknown opcode, repeated adds, pc wrap
        model_mem[0] = 8'h0E;
        model_mem[1] = 8'h53;
        for (int i = 2; i < 14; i++) model_mem[i] = 8'h1F;
        model_mem[14] = 8'h01;
        model_mem[15] = 8'h01;
        run_model(22, stopped);
        chk(stopped == 1'b0, "R9", "model run without stop", stopped, 0);
        load_and_reset();
        drain();
        chk(halted == 1'b0, "R9", "no halt after unknown opcode", halted, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule